// File: doc/BRIEF.md
# Bit-Line Shift-Add Combiner with Serial Multiply

This block sits behind the column converters of a multi-level memory array whose cells each store two bits. A 32-bit element is spread across 16 columns, and every column delivers a 5-bit digitized sum. For each of 8 independent SIMD lanes the block rebuilds a full 32-bit word from those 16 column sums. Column k carries weight 4^k. Signed data needs no special treatment, because a word stored as base-4 complement is the same bit pattern as ordinary two's complement.

It has two operating modes. In the n-ary add mode one pass of column sums is captured and combined; the column sums are what the array produces when several rows are activated at once. In the element-wise multiply mode the block latches a 32-bit multiplicand per lane and feeds it to the array two bits per cycle, starting with the least significant digit. The partial word returned for digit j is shifted left by 2j bits and added to a running total. Every operation flows through three one-cycle stages: array sample, column combine, and shift-accumulate. An add therefore takes 3 cycles and a 32-bit multiply takes 18.

Top module: `bl_shift_add`

## Requirements
- R1: In add mode (`op_mul`=0), the lane result equals the sum over k=0..15 of column sum k times 4^k, modulo 2^32. `res_valid` is high in the cycle after the 3rd rising edge counted from the edge that accepts `start`.
- R2: The column sum for lane l, column k sits at `col_sum[(l*16+k)*5 +: 5]` and is unsigned. Column k is weighted by 4^k, so it lands at bit position 2k.
- R3: When the column sums come from rows that hold negative values in two's complement, the add result is the signed sum in two's complement with no conversion step.
- R4: In multiply mode, `digit[2l +: 2]` carries bits [2j+1:2j] of lane l's latched multiplicand during the j-th cycle after the accepting edge, for j=0..15. At all other times it is 0.
- R5: In multiply mode, the lane result equals the product of the multiplicand and the word stored in the array, modulo 2^32. `res_valid` is high after the 18th rising edge counted from the accepting edge.
- R6: Each lane's result depends only on that lane's column sums and multiplicand.
- R7: Results wrap modulo 2^32, and no overflow indication exists.
- R8: `res_valid` is a single-cycle pulse. `result` changes only when a new operation completes and holds its value until then.
- R9: A `start` that arrives while an operation is in flight is ignored, together with its `op_mul` and `mcand`.
- R10: While `rst_n` is low at a rising edge, `res_valid`, `result` and `digit` are all cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op_mul | input | 1 | 0 = n-ary add, 1 = element-wise multiply |
| mcand | input | 256 | Per-lane 32-bit multiplicand, lane l at [32l +: 32] |
| col_sum | input | 640 | Digitized column sums, 8 lanes x 16 columns x 5 bits |
| digit | output | 16 | Per-lane multiplicand digit driven to the array |
| result | output | 256 | Per-lane 32-bit result, lane l at [32l +: 32] |
| res_valid | output | 1 | One-cycle completion pulse |

## Verification
The bench puts full-scale values on each column in turn. A wrong weight on column 15 would silently corrupt bits 30 and 31, and an off-by-one in the weighting would shift the whole word. Multiply runs place every nonzero digit value in every digit position. A mistake in the shift schedule, or a top digit dropped from the stream, shows up as a product missing its high part. Negative addends, large wrapping sums, and corner multiplicands such as all-ones and 0x80000000 catch a design that sign-corrects the top digit or saturates instead of wrapping. Start pulses issued mid-multiply catch a unit that relaunches: its digit stream, its result, and the number of `res_valid` pulses would all come out wrong.

// File: rtl/bl_sa_pkg.sv
// Shared definitions for the bit-line shift-add combiner.
// Assumes: mode encoding matches the op_mul port (0 add, 1 multiply).
package bl_sa_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } op_e;
endpackage

// File: rtl/bl_sa_weigh.sv
// Combines one lane's column sums into a word: column k weighted by 4^k.
// Assumes: sums are unsigned; anything above WORD_W bits is discarded.
module bl_sa_weigh #(
    parameter int WORD_W = 32,
    parameter int CELL_W = 2,
    parameter int SUM_W  = 5,
    localparam int NCOL  = WORD_W / CELL_W
) (
    input  logic [NCOL*SUM_W-1:0] cols,
    output logic [WORD_W-1:0]     word
);
    // Weighted sum of all columns, wrapping at the word width.
    always_comb begin
        word = '0;
        for (int k = 0; k < NCOL; k++) begin
            word = word + (WORD_W'(cols[k*SUM_W +: SUM_W]) << (k * CELL_W));
        end
    end
endmodule

// File: rtl/bl_sa_lane.sv
// One SIMD lane: samples column sums, combines them, and accumulates
// shifted partial words into the lane result.
// Assumes: control strobes come from bl_sa_seq, one stage apart.
module bl_sa_lane #(
    parameter int WORD_W = 32,
    parameter int CELL_W = 2,
    parameter int SUM_W  = 5,
    localparam int NCOL  = WORD_W / CELL_W,
    localparam int STEP_W = $clog2(NCOL)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_en,
    input  logic [NCOL*SUM_W-1:0]  cols_in,
    input  logic                   part_en,
    input  logic                   acc_en,
    input  logic                   acc_first,
    input  logic                   acc_last,
    input  logic [STEP_W-1:0]      acc_shift,
    output logic [WORD_W-1:0]      result
);
    logic [NCOL*SUM_W-1:0] col_q;
    logic [WORD_W-1:0]     part_comb;
    logic [WORD_W-1:0]     part_q;
    logic [WORD_W-1:0]     acc_q;
    logic [WORD_W-1:0]     acc_next;

    bl_sa_weigh #(.WORD_W(WORD_W), .CELL_W(CELL_W), .SUM_W(SUM_W)) u_weigh (
        .cols (col_q),
        .word (part_comb)
    );

    // Next accumulator value: restart on the first step, add shifted part.
    always_comb begin
        acc_next = (acc_first ? '0 : acc_q) + (part_q << (acc_shift * CELL_W));
    end

    // Stage 1: sample the array's column sums.
    always_ff @(posedge clk) begin
        if (!rst_n) col_q <= '0;
        else if (cap_en) col_q <= cols_in;
    end

    // Stage 2: hold the combined partial word.
    always_ff @(posedge clk) begin
        if (!rst_n) part_q <= '0;
        else if (part_en) part_q <= part_comb;
    end

    // Stage 3: accumulate, and publish the result on the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            result <= '0;
        end else if (acc_en) begin
            acc_q <= acc_next;
            if (acc_last) result <= acc_next;
        end
    end

    // R8: the result moves only on a completing accumulate step.
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && acc_last) |=> $stable(result));
endmodule

// File: rtl/bl_sa_seq.sv
// Operation sequencer: accepts start when idle, streams multiplicand
// digits, and walks the stage strobes for sample, combine, accumulate.
// Assumes: add is a single pass; multiply takes one pass per digit.
module bl_sa_seq
    import bl_sa_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int WORD_W = 32,
    parameter int CELL_W = 2,
    localparam int NCOL  = WORD_W / CELL_W,
    localparam int STEP_W = $clog2(NCOL)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      op_mul,
    input  logic [LANES*WORD_W-1:0]   mcand,
    output logic [LANES*CELL_W-1:0]   digit,
    output logic                      cap_en,
    output logic                      part_en,
    output logic                      acc_en,
    output logic                      acc_first,
    output logic                      acc_last,
    output logic [STEP_W-1:0]         acc_shift,
    output logic                      done
);
    logic              busy;
    op_e               mode_q;
    logic              xb_vld;
    logic [STEP_W-1:0] xb_step;
    logic              xb_last;
    logic              a_vld, a_first, a_last;
    logic [STEP_W-1:0] a_step;
    logic              b_vld, b_first, b_last;
    logic [STEP_W-1:0] b_step;
    logic              launch;

    assign launch  = start && !busy;
    assign xb_last = (mode_q == OP_ADD) || (xb_step == STEP_W'(NCOL - 1));

    // Busy flag, mode latch and array-stage step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            mode_q  <= OP_ADD;
            xb_vld  <= 1'b0;
            xb_step <= '0;
        end else begin
            if (b_vld && b_last) busy <= 1'b0;
            if (launch) begin
                busy    <= 1'b1;
                mode_q  <= op_e'(op_mul);
                xb_vld  <= 1'b1;
                xb_step <= '0;
            end else if (xb_vld) begin
                if (xb_last) xb_vld <= 1'b0;
                else xb_step <= xb_step + STEP_W'(1);
            end
        end
    end

    // Per-lane multiplicand shifter feeding the digit output.
    for (genvar l = 0; l < LANES; l++) begin : g_lane_sh
        logic [WORD_W-1:0] sh_q;
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else if (launch) sh_q <= mcand[l*WORD_W +: WORD_W];
            else if (xb_vld && !xb_last) sh_q <= sh_q >> CELL_W;
        end
        assign digit[l*CELL_W +: CELL_W] =
            (xb_vld && mode_q == OP_MUL) ? sh_q[CELL_W-1:0] : '0;
    end

    // Sample and combine stage control, one cycle behind each other.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_vld <= 1'b0; a_first <= 1'b0; a_last <= 1'b0; a_step <= '0;
            b_vld <= 1'b0; b_first <= 1'b0; b_last <= 1'b0; b_step <= '0;
            done  <= 1'b0;
        end else begin
            a_vld   <= xb_vld;
            a_first <= (xb_step == '0);
            a_last  <= xb_last;
            a_step  <= xb_step;
            b_vld   <= a_vld;
            b_first <= a_first;
            b_last  <= a_last;
            b_step  <= a_step;
            done    <= b_vld && b_last;
        end
    end

    assign cap_en    = xb_vld;
    assign part_en   = a_vld;
    assign acc_en    = b_vld;
    assign acc_first = b_first;
    assign acc_last  = b_last;
    assign acc_shift = b_step;

    // R8: completion is a one-cycle pulse.
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: a start while busy leaves the latched mode untouched.
    a_r9_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(mode_q));
    // R4: digits advance by exactly one position per cycle.
    a_r4_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
        xb_vld && !xb_last |=> xb_vld && (xb_step == $past(xb_step) + STEP_W'(1)));
    // R1: an add makes a single combine pass.
    a_r1_add_single_pass: assert property (@(posedge clk) disable iff (!rst_n)
        part_en && (mode_q == OP_ADD) |=> !part_en);
    // R5: a multiply finishes on its top digit position.
    a_r5_mul_length: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && acc_last && (mode_q == OP_MUL) |-> acc_shift == STEP_W'(NCOL - 1));
endmodule

// File: rtl/bl_shift_add.sv
// Bit-line shift-add combiner: rebuilds per-lane words from 2-bit-cell
// column sums in add mode, or accumulates a serial 2-bit-digit multiply.
// Assumes: col_sum reflects the array's response to the current digit.
module bl_shift_add #(
    parameter int LANES  = 8,
    parameter int WORD_W = 32,
    parameter int CELL_W = 2,
    parameter int SUM_W  = 5,
    localparam int NCOL  = WORD_W / CELL_W,
    localparam int STEP_W = $clog2(NCOL)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          op_mul,
    input  logic [LANES*WORD_W-1:0]       mcand,
    input  logic [LANES*NCOL*SUM_W-1:0]   col_sum,
    output logic [LANES*CELL_W-1:0]       digit,
    output logic [LANES*WORD_W-1:0]       result,
    output logic                          res_valid
);
    logic              cap_en, part_en, acc_en, acc_first, acc_last;
    logic [STEP_W-1:0] acc_shift;

    bl_sa_seq #(.LANES(LANES), .WORD_W(WORD_W), .CELL_W(CELL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_mul    (op_mul),
        .mcand     (mcand),
        .digit     (digit),
        .cap_en    (cap_en),
        .part_en   (part_en),
        .acc_en    (acc_en),
        .acc_first (acc_first),
        .acc_last  (acc_last),
        .acc_shift (acc_shift),
        .done      (res_valid)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bl_sa_lane #(.WORD_W(WORD_W), .CELL_W(CELL_W), .SUM_W(SUM_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .cap_en    (cap_en),
            .cols_in   (col_sum[l*NCOL*SUM_W +: NCOL*SUM_W]),
            .part_en   (part_en),
            .acc_en    (acc_en),
            .acc_first (acc_first),
            .acc_last  (acc_last),
            .acc_shift (acc_shift),
            .result    (result[l*WORD_W +: WORD_W])
        );
    end
endmodule

// File: tb/bl_shift_add_test.sv
`timescale 1ns/1ps
module bl_shift_add_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_mul = 1'b0;
    logic [255:0] mcand = '0;
    logic [639:0] col_sum;
    logic [15:0]  digit;
    logic [255:0] result;
    logic         res_valid;

    int n_chk = 0;
    int n_fail = 0;

    // Behavioural array model state.
    int          kind = 0;           // 0 direct columns, 1 row add, 2 multiply
    logic [4:0]  dcol [8][16];
    logic [31:0] rows [8][8];
    int          nrows = 0;
    logic [31:0] stored [8];
    logic [31:0] expv [8];
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    bl_shift_add uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_mul(op_mul),
        .mcand(mcand), .col_sum(col_sum), .digit(digit),
        .result(result), .res_valid(res_valid)
    );

    // Array response to the present digit or row set.
    always_comb begin
        col_sum = '0;
        for (int l = 0; l < 8; l++) begin
            for (int k = 0; k < 16; k++) begin
                logic [4:0] s;
                s = '0;
                if (kind == 0) s = dcol[l][k];
                else if (kind == 1) begin
                    for (int r = 0; r < 8; r++)
                        if (r < nrows) s = s + 5'(rows[l][r][2*k +: 2]);
                end else s = 5'(stored[l][2*k +: 2]) * 5'(digit[2*l +: 2]);
                col_sum[(l*16+k)*5 +: 5] = s;
            end
        end
    end

    function automatic logic [31:0] nxt();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Launch one operation and check its timing, digits and lane results.
    task automatic run_op(input string req, input logic mul, input logic [255:0] mc, input bit poke);
        int n;
        logic [255:0] held;
        n = mul ? 18 : 3;
        @(negedge clk);
        op_mul = mul; mcand = mc; start = 1'b1;
        @(posedge clk);
        for (int c = 0; c <= n; c++) begin
            if (c > 0) @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            if (poke && (c == 2 || c == 5 || c == 9)) begin
                start = 1'b1; op_mul = 1'b0; mcand = ~mc;   // R9 stray start
            end
            if (mul && c < 16) begin
                logic [15:0] ed;
                for (int l = 0; l < 8; l++) ed[2*l +: 2] = mc[l*32 + 2*c +: 2];
                chk({req, " R4 digit"}, 32'(digit), 32'(ed));
            end
            if (c == 16 || (!mul && c == 1)) chk({req, " R4 idle digit"}, 32'(digit), 32'h0);
            if (c == n - 1) chk({req, " R8 early valid"}, 32'(res_valid), 32'h0);
            if (c == n)     chk({req, " valid timing"}, 32'(res_valid), 32'h1);
        end
        for (int l = 0; l < 8; l++) chk({req, " R6 lane"}, result[l*32 +: 32], expv[l]);
        held = result;
        @(posedge clk); @(negedge clk);
        chk({req, " R8 pulse"}, 32'(res_valid), 32'h0);
        @(posedge clk); @(negedge clk);
        chk({req, " R8 hold"}, 32'(result == held), 32'h1);
    endtask

    task automatic prep_rows(input int nr);
        nrows = nr; kind = 1;
        for (int l = 0; l < 8; l++) begin
            expv[l] = '0;
            for (int r = 0; r < 8; r++) if (r < nr) expv[l] = expv[l] + rows[l][r];
        end
    endtask

    task automatic prep_mul(input logic [255:0] mc);
        kind = 2;
        for (int l = 0; l < 8; l++) expv[l] = stored[l] * mc[l*32 +: 32];
    endtask

    initial begin
        for (int l = 0; l < 8; l++) begin
            stored[l] = '0;
            for (int k = 0; k < 16; k++) dcol[l][k] = '0;
            for (int r = 0; r < 8; r++) rows[l][r] = '0;
        end
        // R10: state during and just after reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 valid", 32'(res_valid), 32'h0);
        chk("R10 digit", 32'(digit), 32'h0);
        for (int l = 0; l < 8; l++) chk("R10 result", result[l*32 +: 32], 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 valid after release", 32'(res_valid), 32'h0);

        // R2 and R1: each column alone at several levels, lanes differ (R6).
        for (int k = 0; k < 16; k++) begin
            for (int v = 0; v < 3; v++) begin
                kind = 0;
                for (int l = 0; l < 8; l++) begin
                    logic [4:0] val;
                    val = (v == 0) ? 5'd31 : 5'((k + l + v * 7) % 31 + 1);
                    if (l == 3) val = 5'd0;
                    for (int j = 0; j < 16; j++) dcol[l][j] = (j == k) ? val : 5'd0;
                    expv[l] = 32'(val) << (2 * k);
                end
                run_op("R2 column weight", 1'b0, '0, 1'b0);
            end
        end
        // R1: all columns loaded at once.
        for (int t = 0; t < 6; t++) begin
            kind = 0;
            for (int l = 0; l < 8; l++) begin
                expv[l] = '0;
                for (int k = 0; k < 16; k++) begin
                    dcol[l][k] = 5'(nxt() % 32);
                    expv[l] = expv[l] + (32'(dcol[l][k]) << (2 * k));
                end
            end
            run_op("R1 full add", 1'b0, '0, 1'b0);
        end
        // R3: signed rows, two to eight addends.
        for (int t = 0; t < 12; t++) begin
            for (int l = 0; l < 8; l++)
                for (int r = 0; r < 8; r++)
                    rows[l][r] = (r % 2 == 0) ? -(nxt() % 32'd100000) : (nxt() % 32'd5000);
            prep_rows(2 + t % 7);
            run_op("R3 signed add", 1'b0, '0, 1'b0);
        end
        // R7: sums that cross 2^32.
        for (int l = 0; l < 8; l++)
            for (int r = 0; r < 8; r++)
                rows[l][r] = (l % 2 == 0) ? 32'hFFFF_FFFF : 32'h7FFF_FFFF + 32'(r);
        prep_rows(8);
        run_op("R7 wrap add", 1'b0, '0, 1'b0);

        // R5: every digit value in every position.
        for (int l = 0; l < 8; l++) stored[l] = 32'h9E37_79B9 + 32'(l * 977);
        for (int j = 0; j < 16; j++) begin
            for (int d = 1; d < 4; d++) begin
                logic [255:0] mc;
                for (int l = 0; l < 8; l++) mc[l*32 +: 32] = 32'(d) << (2 * j);
                prep_mul(mc);
                run_op("R5 digit sweep", 1'b1, mc, 1'b0);
            end
        end
        // R5 and R7: corner multiplicands and stored words.
        for (int t = 0; t < 4; t++) begin
            logic [255:0] mc;
            for (int l = 0; l < 8; l++) begin
                stored[l] = (t == 0) ? 32'hFFFF_FFFF : nxt();
                case (l % 4)
                    0: mc[l*32 +: 32] = 32'h8000_0000;
                    1: mc[l*32 +: 32] = 32'hFFFF_FFFF;
                    2: mc[l*32 +: 32] = (t == 1) ? 32'h0 : 32'h1;
                    default: mc[l*32 +: 32] = nxt();
                endcase
            end
            prep_mul(mc);
            run_op("R7 mul corner", 1'b1, mc, 1'b0);
        end
        // R5: general products.
        for (int t = 0; t < 10; t++) begin
            logic [255:0] mc;
            for (int l = 0; l < 8; l++) begin
                stored[l] = nxt();
                mc[l*32 +: 32] = nxt();
            end
            prep_mul(mc);
            run_op("R5 mul", 1'b1, mc, 1'b0);
        end
        // R9: stray starts during a multiply.
        for (int t = 0; t < 3; t++) begin
            logic [255:0] mc;
            for (int l = 0; l < 8; l++) begin
                stored[l] = nxt();
                mc[l*32 +: 32] = nxt();
            end
            prep_mul(mc);
            run_op("R9 busy start", 1'b1, mc, 1'b1);
        end
        @(negedge clk);
        chk("R9 no relaunch", 32'(res_valid), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule